// File: doc/BRIEF.md
# Stack Push/Pull/Return Sequencer

This controller executes the stack instructions of an 8-bit processor core. These are the two register pushes, the two register pulls, the return from interrupt, the return from subroutine, and the step of a multiply that stores the upper product byte on the stack. It owns the 8-bit stack pointer and drives a byte-wide memory port. Register updates reach the core through load strobes for the accumulator, the status byte and the 16-bit program counter.

A push stores the value at the current stack location and then moves the pointer down. A pull moves the pointer up and then reads. Stack addresses always lie in page 0x01. The memory is synchronous: read data appears on `mem_rdata` in the cycle after the address is presented. Any write completes at the clock edge that ends its cycle.

The core raises `start` with an opcode while `busy` is low. `done` pulses for one cycle once the instruction has finished.

Top module: `stack_seq`

## Requirements
- R1: After reset the stack pointer is 0xFF, `busy` and `done` are low, and no write enable or load strobe is active.
- R2: PHA (0x48) and PHP (0x08) spend one cycle writing `acc_in` or `ps_in`, captured at start, to address {0x01, S}. S then drops by one, and `done` is high in the following cycle.
- R3: The multiply push (0x82) writes `prod_in[15:8]` to {0x01, S} and decrements S. In that same write cycle it pulses `a_ld` with `a_out` = `prod_in[7:0]`.
- R4: PLA (0x68) increments S, reads {0x01, S} and loads A from the data read. It also loads PS with bit 7 (negative) copied from the data and bit 1 (zero) set exactly when the data is 0x00. All other bits come from `ps_in`.
- R5: PLP (0x28) increments S, reads {0x01, S} and loads the whole status byte from the data read. It leaves A untouched.
- R6: RTI (0x40) performs three pulls from successive rising addresses, in the order status, PC low, PC high. It pulses `ps_ld` on the first and `pc_ld` once, on the third, with {high, low}.
- R7: RTS (0x60) pulls PC low and then PC high. It loads PC with {high, low} + 1, and the carry propagates from the low byte into the high byte (0xFFFF becomes 0x0000).
- R8: S wraps modulo 256 in both directions. A pull at 0xFF uses address 0x0100, and a push at 0x00 leaves S at 0xFF.
- R9: `start` is ignored while `busy` is high. Opcodes outside the seven listed are ignored in idle, leaving S, memory and every strobe unchanged.
- R10: A push keeps `busy` high for 1 cycle and a pull sequence of n bytes for 2n+1 cycles. `done` is a single-cycle pulse in the cycle after the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (accepted only while idle) |
| opcode | input | 8 | Instruction code |
| acc_in | input | 8 | Current accumulator |
| ps_in | input | 8 | Current status byte |
| prod_in | input | 16 | Multiply product |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| sp | output | 8 | Stack pointer |
| a_out | output | 8 | Accumulator load value |
| a_ld | output | 1 | Accumulator load strobe |
| ps_out | output | 8 | Status load value |
| ps_ld | output | 1 | Status load strobe |
| pc_out | output | 16 | Program counter load value |
| pc_ld | output | 1 | Program counter load strobe |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Single-cycle completion pulse |

## Verification
A wrong stack pointer appears on `sp` and `mem_addr` in the very cycle it goes wrong, so the per-cycle comparison catches it at once. A wrong step counter or state shows up as strobes that fire in the wrong cycle, or as a `done` that arrives early or late. These faults are visible within one or two cycles of the bad transition. Corrupted captured data, such as the saved low PC byte or the latched push value, only becomes visible at the final load or write of the instruction. For that reason the returns are run with byte values that differ from one another and with an all-ones PC that exercises the carry.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter logic [7:0] SP_INIT = 8'hFF,
  parameter logic [7:0] PAGE    = 8'h01,
  parameter logic [7:0] OP_PHA  = 8'h48,
  parameter logic [7:0] OP_PHP  = 8'h08,
  parameter logic [7:0] OP_MUL  = 8'h82,
  parameter logic [7:0] OP_PLA  = 8'h68,
  parameter logic [7:0] OP_PLP  = 8'h28,
  parameter logic [7:0] OP_RTI  = 8'h40,
  parameter logic [7:0] OP_RTS  = 8'h60,
  parameter int         N_BIT   = 7,
  parameter int         Z_BIT   = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [7:0]  acc_in,
  input  logic [7:0]  ps_in,
  input  logic [15:0] prod_in,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  sp,
  output logic [7:0]  a_out,
  output logic        a_ld,
  output logic [7:0]  ps_out,
  output logic        ps_ld,
  output logic [15:0] pc_out,
  output logic        pc_ld,
  output logic        busy,
  output logic        done
);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_INC, S_RD, S_CAP} st_t;

  st_t        st;
  logic [7:0] op_q, wval_q, lo_q, pcl_q;
  logic [1:0] cnt;

  wire is_push = (opcode == OP_PHA) || (opcode == OP_PHP) || (opcode == OP_MUL);
  wire is_pull = (opcode == OP_PLA) || (opcode == OP_PLP) ||
                 (opcode == OP_RTI) || (opcode == OP_RTS);

  wire is_rti = (op_q == OP_RTI);
  wire is_rts = (op_q == OP_RTS);
  wire is_pla = (op_q == OP_PLA);
  wire is_mul = (op_q == OP_MUL);

  wire [1:0] last     = is_rti ? 2'd2 : (is_rts ? 2'd1 : 2'd0);
  wire [1:0] pcl_step = is_rti ? 2'd1 : 2'd0;
  wire       cap      = (st == S_CAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sp     <= SP_INIT;
      op_q   <= '0;
      wval_q <= '0;
      lo_q   <= '0;
      pcl_q  <= '0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start && is_push) begin
            op_q   <= opcode;
            wval_q <= (opcode == OP_PHA) ? acc_in :
                      (opcode == OP_PHP) ? ps_in : prod_in[15:8];
            lo_q   <= prod_in[7:0];
            st     <= S_WR;
          end else if (start && is_pull) begin
            op_q <= opcode;
            cnt  <= '0;
            st   <= S_INC;
          end
        end
        S_WR: begin
          sp   <= sp - 8'd1;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        S_INC: begin
          sp <= sp + 8'd1;
          st <= S_RD;
        end
        S_RD: st <= S_CAP;
        S_CAP: begin
          if (cnt == pcl_step) pcl_q <= mem_rdata;
          if (cnt == last) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            sp  <= sp + 8'd1;
            cnt <= cnt + 2'd1;
            st  <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [7:0] flag_merge;
  always_comb begin
    flag_merge        = ps_in;
    flag_merge[N_BIT] = mem_rdata[7];
    flag_merge[Z_BIT] = (mem_rdata == 8'h00);
  end

  assign busy      = (st != S_IDLE);
  assign mem_addr  = {PAGE, sp};
  assign mem_we    = (st == S_WR);
  assign mem_wdata = wval_q;

  assign a_ld   = (mem_we && is_mul) || (cap && is_pla);
  assign a_out  = is_mul ? lo_q : mem_rdata;
  assign ps_ld  = cap && (is_pla || (op_q == OP_PLP) || (is_rti && cnt == 2'd0));
  assign ps_out = is_pla ? flag_merge : mem_rdata;
  assign pc_ld  = cap && (is_rti || is_rts) && (cnt == last);
  assign pc_out = {mem_rdata, pcl_q} + {15'd0, is_rts};

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  sp,
  input logic        mem_we,
  input logic        a_ld,
  input logic        ps_ld,
  input logic        pc_ld,
  input logic        busy,
  input logic        done
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp == 8'($past(sp) - 8'd1)));

  // R8
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp != $past(sp)) |-> ((sp == 8'($past(sp) + 8'd1)) || (sp == 8'($past(sp) - 8'd1))));

  // R9
  write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> busy);

  // R6
  pc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld |-> (!a_ld && !mem_we));

  // R5
  ld_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ld || ps_ld || pc_ld) |-> busy);

endmodule

bind stack_seq stack_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sp(sp), .mem_we(mem_we), .a_ld(a_ld),
  .ps_ld(ps_ld), .pc_ld(pc_ld), .busy(busy), .done(done)
);

// File: tb/stack_seq_test.sv
module stack_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  acc_in = 8'h00;
  logic [7:0]  ps_in = 8'hC3;
  logic [15:0] prod_in = 16'h0000;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  sp, a_out, ps_out;
  logic        a_ld, ps_ld, pc_ld, busy, done;
  logic [15:0] pc_out;

  logic [7:0] mem [256];
  int checks = 0, errors = 0;
  int msp = 255;
  bit finished = 0;

  always #2 clk = ~clk;

  stack_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .acc_in(acc_in),
    .ps_in(ps_in), .prod_in(prod_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .sp(sp), .a_out(a_out), .a_ld(a_ld),
    .ps_out(ps_out), .ps_ld(ps_ld), .pc_out(pc_out), .pc_ld(pc_ld),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_view(string req);
    chk(req, "busy", busy, 0);
    chk(req, "we", mem_we, 0);
    chk(req, "sp", sp, msp);
    chk(req, "strobes", {a_ld, ps_ld, pc_ld}, 0);
  endtask

  task automatic do_push(string req, logic [7:0] op, logic [7:0] val, logic [7:0] lo);
    int old = msp;
    opcode = op; start = 1'b1;
    step(); start = 1'b0;
    chk(req, "busy", busy, 1);
    chk(req, "done", done, 0);
    chk(req, "we", mem_we, 1);
    chk(req, "addr", mem_addr, 16'h0100 | old);
    chk(req, "wdata", mem_wdata, val);
    chk(req, "sp", sp, old);
    chk(req, "a_ld", a_ld, (op == 8'h82) ? 1 : 0);
    if (op == 8'h82) chk("R3", "a_out", a_out, lo);
    chk(req, "ps/pc ld", {ps_ld, pc_ld}, 0);
    step();
    msp = (msp - 1) & 255;
    chk(req, "done", done, 1);
    chk("R10", "busy after push", busy, 0);
    chk(req, "sp after", sp, msp);
    chk(req, "mem written", mem[old], val);
    step();
    chk("R10", "done pulse", done, 0);
  endtask

  task automatic do_pull(string req, logic [7:0] op, int n, bit poke);
    logic [7:0] pcl = 8'h00;
    opcode = op; start = 1'b1;
    step(); start = 1'b0;
    if (poke) begin opcode = 8'h48; start = 1'b1; end
    chk(req, "busy", busy, 1);
    chk(req, "we", mem_we, 0);
    chk(req, "sp", sp, msp);
    chk(req, "strobes", {a_ld, ps_ld, pc_ld}, 0);
    for (int k = 0; k < n; k++) begin
      msp = (msp + 1) & 255;
      step();
      start = 1'b0;
      chk(req, "rd addr", mem_addr, 16'h0100 | msp);
      chk(req, "rd we", mem_we, 0);
      chk(req, "rd strobes", {a_ld, ps_ld, pc_ld}, 0);
      chk("R10", "done mid", done, 0);
      step();
      begin
        logic [7:0] d = mem[msp];
        int ea = 0, ep = 0, ec = 0;
        if (op == 8'h68) begin
          ea = 1; ep = 1;
          chk(req, "a_out", a_out, d);
          chk(req, "ps_out flags", ps_out,
              (ps_in & 8'h7D) | (d & 8'h80) | ((d == 8'h00) ? 8'h02 : 8'h00));
        end else if (op == 8'h28) begin
          ep = 1;
          chk(req, "ps_out", ps_out, d);
        end else if (op == 8'h40) begin
          if (k == 0) begin ep = 1; chk(req, "ps_out", ps_out, d); end
          if (k == 1) pcl = d;
          if (k == 2) begin ec = 1; chk(req, "pc_out", pc_out, {d, pcl}); end
        end else begin
          if (k == 0) pcl = d;
          if (k == 1) begin ec = 1; chk(req, "pc_out", pc_out, ({d, pcl} + 1) & 16'hFFFF); end
        end
        chk(req, "a_ld", a_ld, ea);
        chk(req, "ps_ld", ps_ld, ep);
        chk(req, "pc_ld", pc_ld, ec);
        chk(req, "cap we", mem_we, 0);
      end
    end
    step();
    chk(req, "done", done, 1);
    chk("R10", "busy end", busy, 0);
    chk(req, "sp end", sp, msp);
    step();
    chk("R10", "done pulse", done, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    mem[0] = 8'h00;
    step(); step();
    // R1 reset state
    chk("R1", "sp", sp, 8'hFF);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "we/strobes", {mem_we, a_ld, ps_ld, pc_ld}, 0);
    rst_n = 1'b1;
    step();
    idle_view("R1");

    // R4 R8: pull wraps FF->00, zero data sets Z
    do_pull("R4", 8'h68, 1, 0);
    chk("R8", "wrap up", sp, 8'h00);
    // R2 R8: push at 00 wraps to FF
    acc_in = 8'h9C;
    do_push("R2", 8'h48, 8'h9C, 8'h00);
    chk("R8", "wrap down", sp, 8'hFF);
    do_push("R2", 8'h08, ps_in, 8'h00);
    prod_in = 16'hBEEF;
    do_push("R3", 8'h82, 8'hBE, 8'hEF);
    // R5
    do_pull("R5", 8'h28, 1, 0);
    // R4 negative data
    do_pull("R4", 8'h68, 1, 0);

    // R7 carry into high byte
    acc_in = 8'h12; do_push("R2", 8'h48, 8'h12, 8'h00);
    acc_in = 8'hFF; do_push("R2", 8'h48, 8'hFF, 8'h00);
    do_pull("R7", 8'h60, 2, 0);

    // R6 with start poked while busy (R9)
    acc_in = 8'h34; do_push("R2", 8'h48, 8'h34, 8'h00);
    acc_in = 8'h56; do_push("R2", 8'h48, 8'h56, 8'h00);
    acc_in = 8'hA5; do_push("R2", 8'h48, 8'hA5, 8'h00);
    do_pull("R6", 8'h40, 3, 1);
    chk("R9", "poke ignored mem", mem[msp], 8'h34);

    // R9 unknown opcode
    opcode = 8'hEA; start = 1'b1;
    step(); start = 1'b0;
    idle_view("R9");
    step();
    idle_view("R9");
    chk("R9", "done", done, 0);

    // R7 all-ones PC rolls to zero
    acc_in = 8'hFF; do_push("R2", 8'h48, 8'hFF, 8'h00);
    acc_in = 8'hFF; do_push("R2", 8'h48, 8'hFF, 8'h00);
    do_pull("R7", 8'h60, 2, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule